// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Synthesizer

This block synthesizes a cosine tone by direct digital synthesis and presents it as two 8-bit DAC codes. A single phase accumulator is shared by both channels. A small prescaler divides the input clock and decides when the accumulator moves. The accumulator then adds a 16-bit frequency step. Its upper bits index a computed cosine table that holds signed samples. The output frequency is f_clk / (div + 1) * step / 65536.

Each channel post-processes the shared sample on its own. It shifts the sample down to reduce amplitude, applies one of four bit-flip patterns, and adds an 8-bit DC offset. A channel enable connects the tone to that channel's output. The bit-flip stage also turns the signed sample into an offset-binary code for the DAC. Flipping only the MSB gives the usual offset-binary code, and flipping every bit except the MSB gives the same tone shifted by half a period.

All configuration arrives on plain input ports, and the codes come out on plain registered outputs. There is no handshake: a DAC samples the codes directly. Channel 0 occupies the low slice of each packed per-channel port.

Top module: `dds_tone_gen`

## Requirements
- R1: While reset is asserted, every output code is 0x00 and the phase is zero.
- R2: The phase is a 16-bit accumulator. On every prescaler tick it adds freq_step, modulo 65536, and its upper 8 bits select the table entry. The tone frequency is therefore f_clk / (clk_div + 1) * freq_step / 65536.
- R3: With tone_en high, the prescaler ticks once every clk_div + 1 clocks, and clk_div = 0 ticks on every clock. Output codes change only on the clock edge of a tick.
- R4: Table entry k (0..255) is round(127 * cos(2*pi*k/256)), with halves rounded away from zero, as a signed 8-bit value. On a tick, each output register loads the code derived from the phase held before that tick's advance.
- R5: ch_scale (2 bits per channel) shifts the signed sample right arithmetically by 0, 1, 2 or 3 places for values 0, 1, 2 and 3. The shift comes before the bit-flip stage.
- R6: ch_invert (2 bits per channel) XORs the scaled sample with 0x00 for value 0, 0xFF for value 1, 0x80 for value 2 and 0x7F for value 3.
- R7: ch_offset (8 bits per channel) is added after the bit-flip stage, modulo 256.
- R8: With equal scale and zero offset, a channel in flip mode 3 outputs 0xFF minus the code of a channel in flip mode 2, which is the same tone 180 degrees out of phase.
- R9: A channel whose ch_en bit is low loads 0x00 on each tick.
- R10: While tone_en is low, the phase, the prescaler and both output codes are cleared at the next clock. After tone_en returns high, the first tick outputs the phase-zero sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_en | input | 1 | Common generator enable |
| clk_div | input | 3 | Prescaler value; tick every clk_div+1 clocks |
| freq_step | input | 16 | Phase increment per tick |
| ch_en | input | 2 | Per-channel output enable |
| ch_scale | input | 4 | Per-channel right-shift amount, 2 bits each |
| ch_invert | input | 4 | Per-channel bit-flip mode, 2 bits each |
| ch_offset | input | 16 | Per-channel DC offset, 8 bits each |
| dac_code | output | 16 | Per-channel registered DAC code, 8 bits each |

## Verification
A half-rate step with the MSB-flip and complement-flip modes side by side separates a correct sign conversion from a swapped one. Their sum also shows the half-period relation. A step of 0x0100 walks through every table entry, which exposes rounding or indexing faults. Sweeping every divider value with random steps shows whether ticks come at the right spacing. Directed runs of each scale, flip mode, wrapping offset, channel enable toggle and common enable toggle separate the post-processing stages from each other. Long random mixes then catch errors in the order of those stages.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int SCALE_W = 2;
  localparam int INV_W   = 2;

  typedef enum logic [INV_W-1:0] {
    FLIP_NONE = 2'd0,
    FLIP_ALL  = 2'd1,
    FLIP_MSB  = 2'd2,
    FLIP_LOW  = 2'd3
  } flip_mode_e;
endpackage

// File: rtl/dds_prescaler.sv
module dds_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run) phase <= '0;
    else if (tick)      phase <= phase + step;
  end
endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut #(
  parameter int AW     = 8,
  parameter int SAMP_W = 8
) (
  input  logic [AW-1:0]            addr,
  output logic signed [SAMP_W-1:0] sample
);
  localparam int  DEPTH = 1 << AW;
  localparam real AMP   = real'((1 << (SAMP_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [SAMP_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam real V  = AMP * $cos(TWO_PI * real'(k) / real'(DEPTH));
    localparam int  IV = (V >= 0.0) ? $rtoi(V + 0.5) : -$rtoi(0.5 - V);
    assign tbl[k] = SAMP_W'(IV);
  end

  assign sample = tbl[addr];
endmodule

// File: rtl/dds_channel.sv
module dds_channel
  import dds_pkg::*;
#(
  parameter int SAMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     tick,
  input  logic                     en,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic [SCALE_W-1:0]       scale,
  input  logic [INV_W-1:0]         invert,
  input  logic [SAMP_W-1:0]        offset,
  output logic [SAMP_W-1:0]        code
);
  localparam logic [SAMP_W-1:0] MSB_MASK = {1'b1, {(SAMP_W-1){1'b0}}};

  logic signed [SAMP_W-1:0] shifted;
  logic [SAMP_W-1:0]        mask;
  logic [SAMP_W-1:0]        next_code;

  always_comb begin
    shifted = sample >>> scale;
    unique case (flip_mode_e'(invert))
      FLIP_NONE: mask = '0;
      FLIP_ALL:  mask = '1;
      FLIP_MSB:  mask = MSB_MASK;
      FLIP_LOW:  mask = ~MSB_MASK;
      default:   mask = '0;
    endcase
    next_code = (shifted ^ mask) + offset;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) code <= '0;
    else if (tick)      code <= en ? next_code : '0;
  end
endmodule

// File: rtl/dds_tone_gen.sv
module dds_tone_gen
  import dds_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 8,
  parameter int SAMP_W  = 8,
  parameter int DIV_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tone_en,
  input  logic [DIV_W-1:0]           clk_div,
  input  logic [PHASE_W-1:0]         freq_step,
  input  logic [NUM_CH-1:0]          ch_en,
  input  logic [NUM_CH*SCALE_W-1:0]  ch_scale,
  input  logic [NUM_CH*INV_W-1:0]    ch_invert,
  input  logic [NUM_CH*SAMP_W-1:0]   ch_offset,
  output logic [NUM_CH*SAMP_W-1:0]   dac_code
);
  logic                     tick;
  logic [PHASE_W-1:0]       phase;
  logic signed [SAMP_W-1:0] sample;

  dds_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(tone_en), .div(clk_div), .tick(tick)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(tone_en), .tick(tick),
    .step(freq_step), .phase(phase)
  );

  dds_cos_lut #(.AW(LUT_AW), .SAMP_W(SAMP_W)) u_lut (
    .addr(phase[PHASE_W-1 -: LUT_AW]), .sample(sample)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dds_channel #(.SAMP_W(SAMP_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (tone_en),
      .tick   (tick),
      .en     (ch_en[c]),
      .sample (sample),
      .scale  (ch_scale[c*SCALE_W +: SCALE_W]),
      .invert (ch_invert[c*INV_W +: INV_W]),
      .offset (ch_offset[c*SAMP_W +: SAMP_W]),
      .code   (dac_code[c*SAMP_W +: SAMP_W])
    );
  end
endmodule

// File: rtl/dds_tone_gen_chk.sv
module dds_tone_gen_chk #(
  parameter int NUM_CH  = 2,
  parameter int PHASE_W = 16,
  parameter int SAMP_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tone_en,
  input logic [PHASE_W-1:0]       freq_step,
  input logic [NUM_CH-1:0]        ch_en,
  input logic [NUM_CH*SAMP_W-1:0] dac_code,
  input logic [PHASE_W-1:0]       phase,
  input logic                     tick
);
  // R2: the phase advances by exactly the step on a tick
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && tick) |=> (phase == $past(phase) + $past(freq_step)));

  // R3: codes hold between ticks
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && !tick) |=> $stable(dac_code));

  // R10: common disable clears phase and codes
  assert_phase_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> (phase == '0));

  assert_codes_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> (dac_code == '0));

  // R9: a disabled channel loads zero on a tick
  for (genvar c = 0; c < NUM_CH; c++) begin : g_off
    assert_channel_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_en && tick && !ch_en[c]) |=> (dac_code[c*SAMP_W +: SAMP_W] == '0));
  end
endmodule

bind dds_tone_gen dds_tone_gen_chk #(
  .NUM_CH(NUM_CH), .PHASE_W(PHASE_W), .SAMP_W(SAMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .freq_step(freq_step),
  .ch_en(ch_en), .dac_code(dac_code), .phase(phase), .tick(tick)
);

// File: tb/dds_tone_gen_test.sv
module dds_tone_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tone_en = 1'b0;
  logic [2:0]  clk_div = '0;
  logic [15:0] freq_step = 16'h0001;
  logic [1:0]  ch_en = '0;
  logic [3:0]  ch_scale = '0;
  logic [3:0]  ch_invert = '0;
  logic [15:0] ch_offset = '0;
  logic [15:0] dac_code;

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    chk_on = 1'b1;
  bit    r8_on = 1'b0;

  always #5 clk = ~clk;

  dds_tone_gen uut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .clk_div(clk_div),
    .freq_step(freq_step), .ch_en(ch_en), .ch_scale(ch_scale),
    .ch_invert(ch_invert), .ch_offset(ch_offset), .dac_code(dac_code)
  );

  // R4: table entry definition
  function automatic logic signed [7:0] cos_ref(input int k);
    real v;
    int  iv;
    v  = 127.0 * $cos(6.283185307179586 * real'(k) / 256.0);
    iv = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    return 8'(iv);
  endfunction

  // R5, R6, R7: shift, flip, then offset
  function automatic logic [7:0] code_ref(input int k, input logic [1:0] sc,
                                          input logic [1:0] inv, input logic [7:0] off);
    logic signed [7:0] s;
    logic [7:0] m;
    s = cos_ref(k) >>> sc;
    case (inv)
      2'd0: m = 8'h00;
      2'd1: m = 8'hFF;
      2'd2: m = 8'h80;
      default: m = 8'h7F;
    endcase
    return (s ^ m) + off;
  endfunction

  // reference state
  logic [2:0]  m_cnt = '0;
  logic [15:0] m_acc = '0;
  logic [7:0]  m_code [2];

  initial begin
    m_code[0] = '0;
    m_code[1] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n || !tone_en) begin
      m_cnt = '0; m_acc = '0; m_code[0] = '0; m_code[1] = '0;
    end else if (m_cnt >= clk_div) begin
      for (int c = 0; c < 2; c++)
        m_code[c] = ch_en[c] ? code_ref(int'(m_acc[15:8]), ch_scale[c*2 +: 2],
                                        ch_invert[c*2 +: 2], ch_offset[c*8 +: 8]) : 8'h00;
      m_acc = m_acc + freq_step;
      m_cnt = '0;
    end else begin
      m_cnt = m_cnt + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      for (int c = 0; c < 2; c++) begin
        tests++;
        if (dac_code[c*8 +: 8] !== m_code[c]) begin
          fails++;
          $display("FAIL %s ch%0d code got %h expected %h", cur_req, c, dac_code[c*8 +: 8], m_code[c]);
        end
      end
    end
    if (r8_on) begin  // R8: half-period relation between flip modes 2 and 3
      tests++;
      if (8'(dac_code[7:0] + dac_code[15:8]) !== 8'hFF) begin
        fails++;
        $display("FAIL R8 sum got %h expected %h", 8'(dac_code[7:0] + dac_code[15:8]), 8'hFF);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_ch(input int c, input bit en, input logic [1:0] sc,
                        input logic [1:0] inv, input logic [7:0] off);
    ch_en[c] = en;
    ch_scale[c*2 +: 2] = sc;
    ch_invert[c*2 +: 2] = inv;
    ch_offset[c*8 +: 8] = off;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    cur_req = "R1";
    run(4);
    rst_n = 1'b1;
    run(1);

    // R8 and R2: half-rate tone, MSB flip vs complement flip
    cur_req = "R8";
    set_ch(0, 1, 2'd0, 2'd2, 8'h00);
    set_ch(1, 1, 2'd0, 2'd3, 8'h00);
    freq_step = 16'h8000; clk_div = 3'd0; tone_en = 1'b1;
    run(1);
    r8_on = 1'b1;
    run(20);
    tests++;
    if (dac_code[7:0] !== 8'hFF && dac_code[7:0] !== 8'h01) begin
      fails++;
      $display("FAIL R2 half-rate code got %h expected %h or %h", dac_code[7:0], 8'hFF, 8'h01);
    end
    r8_on = 1'b0;

    // R4: walk every table entry
    cur_req = "R4";
    tone_en = 1'b0; run(1);
    set_ch(0, 1, 2'd0, 2'd0, 8'h00);
    set_ch(1, 1, 2'd0, 2'd2, 8'h00);
    freq_step = 16'h0100; tone_en = 1'b1;
    run(260);

    // R3: every divider value with random steps
    cur_req = "R3";
    for (int d = 0; d < 8; d++) begin
      clk_div = 3'(d);
      freq_step = 16'($urandom_range(1, 16'hFFFF));
      run(40);
    end

    // R2: fine step over a long run
    cur_req = "R2";
    clk_div = 3'd0; freq_step = 16'h1234;
    run(200);

    // R5: each shift amount
    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      set_ch(0, 1, 2'(s), 2'd0, 8'h00);
      set_ch(1, 1, 2'(3 - s), 2'd2, 8'h00);
      freq_step = 16'h0700;
      run(60);
    end

    // R6: each flip mode
    cur_req = "R6";
    for (int m = 0; m < 4; m++) begin
      set_ch(0, 1, 2'd0, 2'(m), 8'h00);
      set_ch(1, 1, 2'd1, 2'(3 - m), 8'h00);
      run(60);
    end

    // R7: offsets including wrap
    cur_req = "R7";
    set_ch(0, 1, 2'd0, 2'd2, 8'hFF);
    set_ch(1, 1, 2'd0, 2'd0, 8'h80);
    run(80);

    // R9: channel enables
    cur_req = "R9";
    set_ch(0, 0, 2'd0, 2'd2, 8'h10);
    clk_div = 3'd2;
    run(30);
    ch_en = 2'b01;
    run(30);
    ch_en = 2'b00;
    run(20);

    // R10: common disable and restart from phase zero
    cur_req = "R10";
    ch_en = 2'b11; clk_div = 3'd3; freq_step = 16'h2345;
    run(30);
    tone_en = 1'b0;
    run(5);
    tone_en = 1'b1;
    run(30);

    // random mix across all settings
    cur_req = "R2";
    for (int i = 0; i < 60; i++) begin
      clk_div = 3'($urandom_range(0, 7));
      freq_step = 16'($urandom_range(1, 16'hFFFF));
      ch_en = 2'($urandom_range(0, 3));
      ch_scale = 4'($urandom_range(0, 15));
      ch_invert = 4'($urandom_range(0, 15));
      ch_offset = 16'($urandom_range(0, 16'hFFFF));
      tone_en = ($urandom_range(0, 9) != 0);
      run(40);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule